// File: doc/BRIEF.md
# Lane-Preserving Thread Compactor

This block takes the active mask of a whole thread block and regroups the active threads into as few warps as it can. The thread block has `NUM_WARPS` warps, and each warp is `LANES` lanes wide. Each thread has a zero-based index `t`. Its lane is `t mod LANES` and its home row is `t / LANES`. A thread is only ever placed in its own lane. Because of this, two threads never compete for one lane slot, and the register file needs no crossbar.

The block works one lane column at a time, with one lowest-first priority encoder per column. A `start` pulse loads the mask. Starting on the next cycle, the block emits one compacted warp per cycle until no active thread is left. Each emitted warp carries:
- the thread index for every lane,
- a per-lane occupancy mask,
- a flag on the final warp.

One cycle after the final warp (or one cycle after the start, if the mask was empty), a one-cycle `done` pulse marks the end of the job.

Top module: `tc_compactor`

## Requirements
- R1: After reset, `out_valid_o`, `done_o` and `busy_o` are all low.
- R2: An occupied output lane `l` always carries a thread index `t` with `t mod LANES == l`. Lane `l` sits at bits `[l*TID_W +: TID_W]` of `out_tid_o`, and `TID_W = clog2(NUM_WARPS*LANES)`.
- R3: Within each lane, threads are emitted in ascending index order, one per output warp.
- R4: A lane with no pending thread for a given output warp is an empty slot. Its bit in `out_lanes_o` is 0 and its thread field is 0.
- R5: The number of output warps equals the largest count of active threads in any single lane column. Every output warp has at least one occupied lane.
- R6: With all threads active, output warp k holds threads k*LANES .. k*LANES+LANES-1 in lanes 0..LANES-1. This is the original static arrangement.
- R7: `out_last_o` is high only on the final warp of a job. `done_o` is a single-cycle pulse in the cycle after that final warp.
- R8: A start with an all-zero mask produces no warp, and `done_o` pulses in the cycle after the start.
- R9: A `start_i` pulse while `busy_o` is high is ignored and does not change the warps of the job in progress.
- R10: The first warp of a non-empty job appears in the cycle after the start was sampled. `out_valid_o` is only high when `busy_o` was high in the preceding cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Load `mask_i` and begin a job (ignored while busy) |
| mask_i | input | NUM_WARPS*LANES | Block-wide active mask, bit t = thread t |
| busy_o | output | 1 | Job in progress |
| out_valid_o | output | 1 | A compacted warp is presented |
| out_lanes_o | output | LANES | Per-lane occupancy of the presented warp |
| out_tid_o | output | LANES*TID_W | Thread index per lane, 0 in empty slots |
| out_last_o | output | 1 | Presented warp is the final one of the job |
| done_o | output | 1 | One-cycle end-of-job pulse |

## Verification
The bench builds the block with three warps of four lanes, so twelve threads. At this size a hand-worked mixed pattern exercises a column with two pending threads beside a column with one. A single lane column can also be fully populated, which gives the deepest job of three warps. The full mask, the empty mask, a lone thread in the last row and pseudo-random masks are all enumerable in a short run. A second start is issued while a job is running, to show that it is ignored.

// File: rtl/tc_pkg.sv
package tc_pkg;
    function automatic int width_of(input int count);
        return (count > 1) ? $clog2(count) : 1;
    endfunction
endpackage

// File: rtl/tc_prio_enc.sv
module tc_prio_enc #(
    parameter int WIDTH = 3,
    localparam int IDX_W = tc_pkg::width_of(WIDTH)
) (
    input  logic [WIDTH-1:0] req_i,
    output logic             found_o,
    output logic [IDX_W-1:0] idx_o
);
    always_comb begin
        found_o = |req_i;
        idx_o   = '0;
        for (int i = WIDTH - 1; i >= 0; i--) begin
            if (req_i[i]) idx_o = IDX_W'(i);
        end
    end
endmodule

// File: rtl/tc_lane_column.sv
module tc_lane_column #(
    parameter int NUM_WARPS = 3,
    parameter int LANES     = 4,
    parameter int LANE_IDX  = 0,
    localparam int THREADS  = NUM_WARPS * LANES,
    localparam int TID_W    = tc_pkg::width_of(THREADS),
    localparam int ROW_W    = tc_pkg::width_of(NUM_WARPS)
) (
    input  logic [THREADS-1:0]   mask_i,
    output logic                 found_o,
    output logic [ROW_W-1:0]     row_o,
    output logic [TID_W-1:0]     tid_o
);
    logic [NUM_WARPS-1:0] column;

    for (genvar r = 0; r < NUM_WARPS; r++) begin : g_gather
        assign column[r] = mask_i[r*LANES + LANE_IDX];
    end

    tc_prio_enc #(.WIDTH(NUM_WARPS)) u_enc (
        .req_i   (column),
        .found_o (found_o),
        .idx_o   (row_o)
    );

    always_comb begin
        tid_o = '0;
        if (found_o) tid_o = TID_W'(row_o) * TID_W'(LANES) + TID_W'(LANE_IDX);
    end
endmodule

// File: rtl/tc_compactor.sv
module tc_compactor #(
    parameter int NUM_WARPS = 3,
    parameter int LANES     = 4,
    localparam int THREADS  = NUM_WARPS * LANES,
    localparam int TID_W    = tc_pkg::width_of(THREADS),
    localparam int ROW_W    = tc_pkg::width_of(NUM_WARPS)
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   start_i,
    input  logic [THREADS-1:0]     mask_i,
    output logic                   busy_o,
    output logic                   out_valid_o,
    output logic [LANES-1:0]       out_lanes_o,
    output logic [LANES*TID_W-1:0] out_tid_o,
    output logic                   out_last_o,
    output logic                   done_o
);
    typedef struct packed {
        logic                   busy;
        logic [THREADS-1:0]     mask;
        logic                   valid;
        logic [LANES-1:0]       lanes;
        logic [LANES*TID_W-1:0] tid;
        logic                   last;
        logic                   done;
    } state_t;

    state_t st_d, st_q;

    logic [LANES-1:0]       pick_found;
    logic [LANES*TID_W-1:0] pick_tid;
    logic [ROW_W-1:0]       pick_row [LANES];
    logic [THREADS-1:0]     pick_clear;

    // one encoder per lane column; a thread never leaves its lane
    for (genvar l = 0; l < LANES; l++) begin : g_lane
        tc_lane_column #(
            .NUM_WARPS (NUM_WARPS),
            .LANES     (LANES),
            .LANE_IDX  (l)
        ) u_col (
            .mask_i  (st_q.mask),
            .found_o (pick_found[l]),
            .row_o   (pick_row[l]),
            .tid_o   (pick_tid[l*TID_W +: TID_W])
        );
        for (genvar r = 0; r < NUM_WARPS; r++) begin : g_clr
            assign pick_clear[r*LANES + l] = pick_found[l] && (pick_row[l] == ROW_W'(r));
        end
    end

    always_comb begin
        st_d       = st_q;
        st_d.valid = 1'b0;
        st_d.last  = 1'b0;
        st_d.done  = 1'b0;
        if (!st_q.busy) begin
            if (start_i) begin
                st_d.busy = 1'b1;
                st_d.mask = mask_i;
            end
        end else if (st_q.mask == '0) begin
            st_d.busy = 1'b0;
            st_d.done = 1'b1;
        end else begin
            st_d.valid = 1'b1;
            st_d.lanes = pick_found;
            st_d.tid   = pick_tid;
            st_d.mask  = st_q.mask & ~pick_clear;
            st_d.last  = (st_d.mask == '0);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign busy_o      = st_q.busy;
    assign out_valid_o = st_q.valid;
    assign out_lanes_o = st_q.lanes;
    assign out_tid_o   = st_q.tid;
    assign out_last_o  = st_q.last;
    assign done_o      = st_q.done;
endmodule

// File: rtl/tc_compactor_chk.sv
module tc_compactor_chk #(
    parameter int NUM_WARPS = 3,
    parameter int LANES     = 4,
    localparam int THREADS  = NUM_WARPS * LANES,
    localparam int TID_W    = tc_pkg::width_of(THREADS)
) (
    input logic                   clk,
    input logic                   rst_n,
    input logic                   busy_o,
    input logic                   out_valid_o,
    input logic [LANES-1:0]       out_lanes_o,
    input logic [LANES*TID_W-1:0] out_tid_o,
    input logic                   out_last_o,
    input logic                   done_o
);
    for (genvar l = 0; l < LANES; l++) begin : g_lane
        assert_home_lane_R2: assert property (@(posedge clk) disable iff (!rst_n)
            (out_valid_o && out_lanes_o[l]) |-> ((int'(out_tid_o[l*TID_W +: TID_W]) % LANES) == l));
        assert_empty_slot_R4: assert property (@(posedge clk) disable iff (!rst_n)
            (out_valid_o && !out_lanes_o[l]) |-> (out_tid_o[l*TID_W +: TID_W] == '0));
    end

    assert_warp_nonempty_R5: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid_o |-> (out_lanes_o != '0));
    assert_done_after_last_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid_o && out_last_o) |=> done_o);
    assert_done_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);
    assert_no_warp_with_done_R7: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> !out_valid_o);
    assert_valid_needs_busy_R10: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid_o |-> $past(busy_o));
endmodule

bind tc_compactor tc_compactor_chk #(.NUM_WARPS(NUM_WARPS), .LANES(LANES)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .busy_o      (busy_o),
    .out_valid_o (out_valid_o),
    .out_lanes_o (out_lanes_o),
    .out_tid_o   (out_tid_o),
    .out_last_o  (out_last_o),
    .done_o      (done_o)
);

// File: tb/tc_compactor_test.sv
module tc_compactor_test;
    localparam int NW = 3;
    localparam int LN = 4;
    localparam int TH = NW * LN;
    localparam int TW = tc_pkg::width_of(TH);

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start_i = 1'b0;
    logic [TH-1:0] mask_i = '0;
    logic busy_o, out_valid_o, out_last_o, done_o;
    logic [LN-1:0] out_lanes_o;
    logic [LN*TW-1:0] out_tid_o;

    always #5 clk = ~clk;

    tc_compactor #(.NUM_WARPS(NW), .LANES(LN)) uut (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .mask_i(mask_i),
        .busy_o(busy_o), .out_valid_o(out_valid_o), .out_lanes_o(out_lanes_o),
        .out_tid_o(out_tid_o), .out_last_o(out_last_o), .done_o(done_o)
    );

    int n_checks = 0;
    int n_fail = 0;
    int done_cnt = 0;
    logic [LN*TW-1:0] q_tid[$];
    logic [LN-1:0]    q_lanes[$];
    logic             q_last[$];

    task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // monitor: pops the scoreboard as warps appear
    always @(negedge clk) begin
        if (rst_n) begin
            if (out_valid_o) begin
                if (q_tid.size() == 0) begin
                    chk(1'b0, "R5 extra warp", 64'(out_tid_o), 64'h0);
                end else begin
                    logic [LN*TW-1:0] et;
                    logic [LN-1:0] el;
                    logic ela;
                    et = q_tid.pop_front();
                    el = q_lanes.pop_front();
                    ela = q_last.pop_front();
                    chk(out_lanes_o == el, "R4 lane occupancy", 64'(out_lanes_o), 64'(el));
                    chk(out_tid_o == et, "R2/R3 thread ids", 64'(out_tid_o), 64'(et));
                    chk(out_last_o == ela, "R7 last flag", 64'(out_last_o), 64'(ela));
                end
            end
            if (done_o) begin
                done_cnt++;
                chk(q_tid.size() == 0, "R5 warp count at done", 64'(q_tid.size()), 64'h0);
            end
        end
    end

    task automatic run_mask(input logic [TH-1:0] m, input bit poke_busy, input logic [TH-1:0] m2);
        int nwarps = 0;
        int start_done;
        for (int l = 0; l < LN; l++) begin
            int c = 0;
            for (int r = 0; r < NW; r++) if (m[r*LN + l]) c++;
            if (c > nwarps) nwarps = c;
        end
        for (int k = 0; k < nwarps; k++) begin
            logic [LN*TW-1:0] et = '0;
            logic [LN-1:0] el = '0;
            for (int l = 0; l < LN; l++) begin
                int seen = 0;
                for (int r = 0; r < NW; r++) begin
                    if (m[r*LN + l]) begin
                        if (seen == k) begin
                            el[l] = 1'b1;
                            et[l*TW +: TW] = TW'(r*LN + l);
                        end
                        seen++;
                    end
                end
            end
            q_tid.push_back(et);
            q_lanes.push_back(el);
            q_last.push_back(k == nwarps - 1);
        end
        start_done = done_cnt;
        mask_i = m;
        start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        chk(busy_o == 1'b1 && out_valid_o == 1'b0, "R10 busy before first warp",
            64'({busy_o, out_valid_o}), 64'h2);
        if (poke_busy) begin
            mask_i = m2;
            start_i = 1'b1;
        end
        @(negedge clk);
        start_i = 1'b0;
        if (nwarps == 0)
            chk(done_o == 1'b1 && out_valid_o == 1'b0, "R8 empty job done", 64'({done_o, out_valid_o}), 64'h2);
        else
            chk(out_valid_o == 1'b1, "R10 first warp timing", 64'(out_valid_o), 64'h1);
        for (int i = 0; i < 50 && done_cnt == start_done; i++) @(negedge clk);
        chk(done_cnt == start_done + 1, "R7 done pulse seen", 64'(done_cnt - start_done), 64'h1);
        @(negedge clk);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog expired");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        logic [TH-1:0] lfsr = 12'hACE;
        repeat (3) @(negedge clk);
        chk(!out_valid_o && !done_o && !busy_o, "R1 reset state", 64'({out_valid_o, done_o, busy_o}), 64'h0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(!out_valid_o && !done_o && !busy_o, "R1 idle after reset", 64'({out_valid_o, done_o, busy_o}), 64'h0);
        // R3 R4: mixed pattern, threads 0,1,4,6,7,10,11 -> {0,1,6,7} and {4,--,10,11}
        run_mask(12'b1100_1101_0011, 1'b0, '0);
        // R6: full mask keeps static warps
        run_mask('1, 1'b0, '0);
        // R8: empty mask
        run_mask('0, 1'b0, '0);
        // R5: lone thread in last row, and one full column (three warps)
        run_mask(12'b1000_0000_0000, 1'b0, '0);
        run_mask(12'b0100_0100_0100, 1'b0, '0);
        // R9: second start during a job is ignored
        run_mask(12'b0010_0010_0001, 1'b1, 12'hFFF);
        for (int i = 0; i < 8; i++) begin
            lfsr = {lfsr[TH-2:0], lfsr[11] ^ lfsr[10] ^ lfsr[9] ^ lfsr[3]};
            run_mask(lfsr, 1'b0, '0);
        end
        chk(!busy_o && !out_valid_o, "R9 idle at end", 64'({busy_o, out_valid_o}), 64'h0);
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end
endmodule